// File: doc/BRIEF.md
# Global-History Correlating Branch Predictor

This block predicts the direction of conditional branches. It keeps a table of small saturating counters. Two things select a counter. A few low bits of the branch address pick a row. A shift register holding the outcomes of the most recent resolved branches, from any address, picks a column within that row. Two branches with the same address bits can therefore keep separate predictions, one for each path that led to them.

The fetch stage presents a PC on the lookup side and reads the taken or not-taken guess combinationally in the same cycle. When a branch resolves later in the pipeline, the update side presents its PC and its real outcome for one cycle. On the next clock edge the block trains the counter that the current history selects, then shifts the outcome into the history.

The update side carries a qualifier but no ready signal. The block never applies back-pressure: every cycle with `upd_valid` high is consumed on that clock edge. With the history width set to zero, the block becomes a plain per-address table of counters.

Top module: `corr_bp`

## Requirements
- R1: After reset, every counter is in state 0 and the global history is 0, so every lookup predicts not taken.
- R2: Each counter is 2 bits wide. States 0 and 1 predict not taken (`lkp_taken` = 0), and states 2 and 3 predict taken (`lkp_taken` = 1).
- R3: An update whose outcome is taken (`upd_taken` = 1) moves the selected counter up by one state, and the counter holds at state 3.
- R4: An update whose outcome is not taken (`upd_taken` = 0) moves the selected counter down by one state, and the counter holds at state 0.
- R5: The table row is PC bits [5:2]. No other PC bit has any effect, so PCs that agree in bits [5:2] share a row.
- R6: Each update shifts the 2-bit global history left by one position and puts the outcome into bit 0 (1 for taken, 0 for not taken). Without an update, the history does not change.
- R7: The selected counter is entry `row*4 + history`. Lookups use the current history. An update trains the entry formed from its own PC row and the history as it was before that update's shift.
- R8: Lookup is combinational. A lookup made in the same cycle as an update sees the table and history from before that update.
- R9: A cycle with `upd_valid` = 0 changes no counter and does not change the history.
- R10: With the history width set to 0, the counter is selected by PC bits [5:2] alone, and counting follows R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lkp_pc | input | PC_W | Fetch PC to predict |
| lkp_taken | output | 1 | Predicted direction for `lkp_pc`, 1 = taken |
| upd_valid | input | 1 | Qualifies a resolved branch this cycle; always accepted |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The assertions assume that `upd_pc` and `upd_taken` hold defined values in every cycle where `upd_valid` is high. They also assume that `upd_valid` itself is never unknown once reset is released. The counter-step and history-shift checks depend on this. The bench drives every input to a defined value on the falling edge. This includes idle cycles, where it keeps random but defined update fields with the qualifier low. It reads the predictions one nanosecond later, so each comparison sees the state left by the previous rising edge.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic {
    BR_NOT_TAKEN = 1'b0,
    BR_TAKEN     = 1'b1
  } br_dir_e;

  function automatic int unsigned hist_port_w(input int unsigned hist_bits);
    return (hist_bits > 0) ? hist_bits : 1;
  endfunction

endpackage

// File: rtl/bp_ghist.sv
module bp_ghist #(
  parameter int unsigned HIST_BITS = 2
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      shift_en,
  input  logic                                      shift_in,
  output logic [bp_pkg::hist_port_w(HIST_BITS)-1:0] hist
);

  generate
    if (HIST_BITS == 0) begin : g_none
      assign hist = '0;
    end else begin : g_sr
      logic [HIST_BITS-1:0] sr_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sr_q <= '0;
        end else if (shift_en) begin
          sr_q <= (sr_q << 1) | HIST_BITS'(shift_in);
        end
      end

      assign hist = sr_q;

      AST_GHIST_NEW_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (sr_q[0] == $past(shift_in)));  // R6

      AST_GHIST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(sr_q));  // R9

      if (HIST_BITS > 1) begin : g_multi
        AST_GHIST_SHIFTS_UP: assert property (@(posedge clk) disable iff (!rst_n)
          shift_en |=> (sr_q[HIST_BITS-1:1] == $past(sr_q[HIST_BITS-2:0])));  // R6
      end
    end
  endgenerate

endmodule

// File: rtl/bp_row_sel.sv
module bp_row_sel #(
  parameter int unsigned PC_W      = 32,
  parameter int unsigned PC_LSB    = 2,
  parameter int unsigned ROW_BITS  = 4,
  parameter int unsigned HIST_BITS = 2
) (
  input  logic [PC_W-1:0]                           pc,
  input  logic [bp_pkg::hist_port_w(HIST_BITS)-1:0] hist,
  output logic [ROW_BITS+HIST_BITS-1:0]             idx
);

  logic [ROW_BITS-1:0] row;
  assign row = pc[PC_LSB +: ROW_BITS];

  generate
    if (HIST_BITS == 0) begin : g_addr_only
      logic unused_hist;
      assign unused_hist = ^hist;
      assign idx = row;
    end else begin : g_corr
      assign idx = {row, hist};
    end
  endgenerate

endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  localparam int unsigned ENTRIES = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CTR_MAX = '1;
  localparam logic [CTR_W-1:0] CTR_MIN = '0;

  logic [CTR_W-1:0] ctr_q [ENTRIES];
  logic [CTR_W-1:0] wr_old;
  logic [CTR_W-1:0] wr_new;

  assign wr_old = ctr_q[wr_idx];

  always_comb begin
    wr_new = wr_old;
    if (wr_taken) begin
      if (wr_old != CTR_MAX) wr_new = wr_old + 1'b1;
    end else begin
      if (wr_old != CTR_MIN) wr_new = wr_old - 1'b1;
    end
  end

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ctr_q[e] <= CTR_MIN;
        end else if (wr_en && (wr_idx == IDX_W'(e))) begin
          ctr_q[e] <= wr_new;
        end
      end
    end
  endgenerate

  assign rd_taken = ctr_q[rd_idx][CTR_W-1];

  AST_CTR_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && (wr_old != CTR_MAX)) |=>
      (ctr_q[$past(wr_idx)] == $past(wr_old) + 1'b1));  // R3

  AST_CTR_HOLD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && (wr_old == CTR_MAX)) |=>
      (ctr_q[$past(wr_idx)] == CTR_MAX));  // R3

  AST_CTR_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && (wr_old != CTR_MIN)) |=>
      (ctr_q[$past(wr_idx)] == $past(wr_old) - 1'b1));  // R4

  AST_CTR_HOLD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && (wr_old == CTR_MIN)) |=>
      (ctr_q[$past(wr_idx)] == CTR_MIN));  // R4

endmodule

// File: rtl/corr_bp.sv
module corr_bp #(
  parameter int unsigned PC_W      = 32,
  parameter int unsigned PC_LSB    = 2,
  parameter int unsigned ROW_BITS  = 4,
  parameter int unsigned HIST_BITS = 2,
  parameter int unsigned CTR_W     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lkp_pc,
  output logic            lkp_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);

  localparam int unsigned IDX_W = ROW_BITS + HIST_BITS;
  localparam int unsigned HW    = bp_pkg::hist_port_w(HIST_BITS);

  bp_pkg::br_dir_e upd_dir;
  logic [HW-1:0]    ghist;
  logic [IDX_W-1:0] lkp_idx;
  logic [IDX_W-1:0] upd_idx;

  assign upd_dir = bp_pkg::br_dir_e'(upd_taken);

  bp_ghist #(.HIST_BITS(HIST_BITS)) u_ghist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (upd_valid),
    .shift_in (upd_dir == bp_pkg::BR_TAKEN),
    .hist     (ghist)
  );

  bp_row_sel #(
    .PC_W(PC_W), .PC_LSB(PC_LSB), .ROW_BITS(ROW_BITS), .HIST_BITS(HIST_BITS)
  ) u_lkp_sel (
    .pc   (lkp_pc),
    .hist (ghist),
    .idx  (lkp_idx)
  );

  bp_row_sel #(
    .PC_W(PC_W), .PC_LSB(PC_LSB), .ROW_BITS(ROW_BITS), .HIST_BITS(HIST_BITS)
  ) u_upd_sel (
    .pc   (upd_pc),
    .hist (ghist),
    .idx  (upd_idx)
  );

  bp_ctr_table #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (lkp_idx),
    .rd_taken (lkp_taken),
    .wr_en    (upd_valid),
    .wr_idx   (upd_idx),
    .wr_taken (upd_dir == bp_pkg::BR_TAKEN)
  );

endmodule

// File: tb/test_corr_bp.sv
`timescale 1ns/1ps
module test_corr_bp;

  localparam time CLK_P = 5ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lkp_pc = '0;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic        lkp_taken;
  logic        lkp_taken_bht;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;

  int unsigned m_ctr [64];
  int unsigned m_flat [16];
  int unsigned m_hist;

  always #(CLK_P/2) clk = ~clk;

  corr_bp i_corr_bp (
    .clk(clk), .rst_n(rst_n), .lkp_pc(lkp_pc), .lkp_taken(lkp_taken),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
  );

  corr_bp #(.HIST_BITS(0)) i_corr_bp_bht (
    .clk(clk), .rst_n(rst_n), .lkp_pc(lkp_pc), .lkp_taken(lkp_taken_bht),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
  );

  function automatic int unsigned row_of(input logic [31:0] pc);
    return (pc >> 2) & 32'hF;
  endfunction

  function automatic bit exp_main(input logic [31:0] pc);
    return m_ctr[row_of(pc) * 4 + m_hist] >= 2;
  endfunction

  function automatic bit exp_flat(input logic [31:0] pc);
    return m_flat[row_of(pc)] >= 2;
  endfunction

  function automatic int unsigned bump(input int unsigned c, input bit t);
    if (t) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic model_reset();
    foreach (m_ctr[i]) m_ctr[i] = 0;
    foreach (m_flat[i]) m_flat[i] = 0;
    m_hist = 0;
  endtask

  task automatic model_update(input logic [31:0] pc, input bit t);
    int unsigned ix;
    ix = row_of(pc) * 4 + m_hist;
    m_ctr[ix] = bump(m_ctr[ix], t);
    m_flat[row_of(pc)] = bump(m_flat[row_of(pc)], t);
    m_hist = ((m_hist << 1) | t) & 3;
  endtask

  task automatic check(input bit got, input bit exp, input string req, input string what);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s pc=%h got=%0b exp=%0b", req, what, lkp_pc, got, exp);
    end
  endtask

  // one cycle: drive at falling edge, compare pre-update state, then mirror the edge
  task automatic step(input logic [31:0] lpc, input bit uv, input logic [31:0] upc,
                      input bit ut, input string req);
    @(negedge clk);
    lkp_pc = lpc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
    #1;
    check(lkp_taken, exp_main(lpc), req, "corr");
    check(lkp_taken_bht, exp_flat(lpc), (req == "R10") ? "R10" : req, "addr-only");
    @(posedge clk);
    if (uv) model_update(upc, ut);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state, every row predicts not taken
    for (int r = 0; r < 16; r++) step(32'(r << 2), 1'b0, 32'h0, 1'b0, "R1");

    // R3 / R8: loop-style branch trained taken, lookup of same pc each cycle
    for (int i = 0; i < 6; i++) step(32'h0000_0040, 1'b1, 32'h0000_0040, 1'b1, "R3");
    // R2: one not-taken step takes a saturated entry from 3 to 2, still taken
    step(32'h0000_0040, 1'b1, 32'h0000_0040, 1'b0, "R2");
    step(32'h0000_0040, 1'b1, 32'h0000_0040, 1'b1, "R2");
    step(32'h0000_0040, 1'b0, 32'h0, 1'b0, "R8");

    // R4: drain to floor and beyond
    for (int i = 0; i < 7; i++) step(32'h0000_0040, 1'b1, 32'h0000_0040, 1'b0, "R4");

    // R5: aliasing through upper pc bits
    for (int i = 0; i < 4; i++) step(32'h0000_0044, 1'b1, 32'hABC0_0044, 1'b1, "R5");
    step(32'h7700_0046, 1'b0, 32'h0, 1'b0, "R5");

    // R6 / R7: alternating outcomes on one branch select different columns
    for (int i = 0; i < 12; i++) step(32'h0000_0088, 1'b1, 32'h0000_0088, 1'(i & 1), "R7");
    for (int i = 0; i < 8; i++) step(32'h0000_0090, 1'b1, 32'h0000_0010, 1'(i % 3 == 0), "R6");

    // R10: per-address view of the history-less instance
    for (int i = 0; i < 6; i++) step(32'h0000_0038, 1'b1, 32'h0000_0038, 1'(i != 2), "R10");

    // R9: idle cycles with defined but unqualified update fields
    for (int i = 0; i < 20; i++) step($urandom, 1'b0, $urandom, 1'($urandom), "R9");

    // random mix, small pc space to force collisions
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] upc;
      upc = {$urandom_range(3, 0) == 0 ? 24'($urandom) : 24'h0, 2'b00, 4'($urandom), 2'($urandom)};
      step({$urandom} & 32'h0000_00FF, ($urandom_range(3, 0) != 0), upc,
           ($urandom_range(4, 0) != 0), "R7");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule